// File: doc/BRIEF.md
# Windowed register file controller

This block gives an instruction a view of 16 logical registers, selected by 4-bit specifiers, into a physical register file of 32 or 64 entries. A window base pointer, counted in groups of four registers, slides forward when a subroutine is entered and back when it returns. Caller and callee windows therefore overlap: the caller passes arguments by writing its high registers, and the callee finds them in its low registers. No save or restore code is needed until the pointer wraps around the physical file.

A call first announces its window advance of 4, 8 or 12 registers. The entry strobe then moves the base by that amount and pushes the advance onto a small stack. The return strobe pops the stack and moves the base back, so nested calls of mixed sizes unwind in order. A mask with one live bit per four-register group tracks which groups hold data of the current call chain. The overflow flag rises when an entry would expose a group that is still live; that group's older contents must be spilled by an outside handler. The underflow flag rises when a return lands on groups that a deeper, wrapped frame has taken over, so their contents must be refilled. In both cases the base still moves, and the groups of the new window are marked live.

The storage has two combinational read ports and one write port, with write-to-read forwarding.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window base is 0, both flags are low, and every physical address equals its logical register number.
- R2: Each read and write physical address equals (4 x window base + logical register) modulo the physical file size.
- R3: A call request with increment code 1, 2 or 3 sets the pending advance to 4, 8 or 12 registers (1, 2 or 3 groups); a request with code 0 leaves the pending advance unchanged; the pending advance is 1 group after reset. An accepted entry adds the pending advance to the window base on the next clock edge.
- R4: A return moves the base back by the advance of the most recent entry not yet returned, so that nested entries of mixed sizes unwind in reverse order.
- R5: Windows overlap: a value that the caller writes at logical register r is read by the callee at logical register r - 4k after an entry that advances by k groups.
- R6: The window base wraps modulo the number of groups (physical size / 4).
- R7: During the cycle of an accepted entry, overflow_o is high exactly when one of the groups newly exposed by the advance (base+4 up to base+3+k) is live. The entry still takes effect.
- R8: During the cycle of an accepted return, underflow_o is high exactly when one of the four caller groups is not live. The return still takes effect, the caller groups become live, and the groups held only by the callee become free.
- R9: A return with an empty increment stack, and an entry with a full stack, have no effect on the base or the flags. When entry and return are strobed together, only the entry acts.
- R10: A read of the physical register that is being written in the same cycle returns the new data.
- R11: Data written on a clock edge is read back afterwards, and the two read ports are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_lreg_i | input | 4 | Logical register of read port A |
| rd_b_lreg_i | input | 4 | Logical register of read port B |
| wr_en_i | input | 1 | Write enable |
| wr_lreg_i | input | 4 | Logical register to write |
| wr_data_i | input | DATA_W | Write data |
| call_req_i | input | 1 | Latch call_inc_i as the pending advance |
| call_inc_i | input | 2 | Advance in groups of four registers (1..3) |
| entry_i | input | 1 | Advance the window by the pending amount |
| return_i | input | 1 | Retreat the window by the most recent advance |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_data_o | output | DATA_W | Read port B data |
| rd_a_paddr_o | output | log2(PHYS_REGS) | Physical address of read port A |
| rd_b_paddr_o | output | log2(PHYS_REGS) | Physical address of read port B |
| wr_paddr_o | output | log2(PHYS_REGS) | Physical address of the write port |
| win_base_o | output | log2(PHYS_REGS)-2 | Current window base, in groups |
| overflow_o | output | 1 | Entry exposes a live group |
| underflow_o | output | 1 | Return reaches a group that is no longer live |

## Verification
The bench builds the block with a 32-entry file, which gives eight groups, and with a four-deep increment stack. With eight groups, two 12-register advances already run into live groups, and three of them wrap the base past zero. Underflow on the way back then follows after a handful of returns. The shallow stack lets the bench reach the full-stack case with four small calls, and it shows at the ports that a fifth entry was dropped, because four returns bring the base back to zero.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  // window advance counted in groups of four registers
  typedef logic [1:0] inc_t;
endpackage

// File: rtl/rwin_inc_stack.sv
module rwin_inc_stack
  import rwin_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  inc_t data_i,
  output inc_t top_o,
  output logic empty_o,
  output logic full_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q;
  inc_t          mem_q [DEPTH];

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign top_o   = mem_q[IW'(cnt_q - CW'(1))];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + CW'(1);
    else if (pop_i && !empty_o) cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[IW'(cnt_q)] <= data_i;
  end

  p_push_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !full_o |=> cnt_q == $past(cnt_q) + CW'(1));

  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> $stable(cnt_q));

  p_pop_then_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !full_o |=> top_o == $past(data_i));
endmodule

// File: rtl/rwin_window.sv
module rwin_window
  import rwin_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_req_i,
  input  inc_t            call_inc_i,
  input  logic            entry_i,
  input  logic            return_i,
  output logic [$clog2(NGRP)-1:0] base_o,
  output logic            overflow_o,
  output logic            underflow_o
);
  localparam int GW = $clog2(NGRP);

  logic [GW-1:0]   base_q, ret_base;
  logic [NGRP-1:0] live_q, need_m, rel_m, caller_m;
  inc_t            pend_q, top_inc;
  logic            stk_empty, stk_full, do_entry, do_ret;

  assign do_entry = entry_i && !stk_full;
  assign do_ret   = return_i && !entry_i && !stk_empty;

  rwin_inc_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (do_entry),
    .pop_i   (do_ret),
    .data_i  (pend_q),
    .top_o   (top_inc),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_comb begin
    need_m   = '0;
    rel_m    = '0;
    caller_m = '0;
    ret_base = base_q - GW'(top_inc);
    for (int j = 1; j <= 3; j++) begin
      if (int'(pend_q) >= j)  need_m[base_q + GW'(3 + j)]  = 1'b1;
      if (int'(top_inc) >= j) rel_m[ret_base + GW'(3 + j)] = 1'b1;
    end
    for (int j = 0; j < 4; j++) caller_m[ret_base + GW'(j)] = 1'b1;
  end

  assign overflow_o  = do_entry && |(need_m & live_q);
  assign underflow_o = do_ret && |(caller_m & ~live_q);
  assign base_o      = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= inc_t'(1);
      base_q <= '0;
      live_q <= NGRP'(4'hF);
    end else begin
      if (call_req_i && call_inc_i != '0) pend_q <= call_inc_i;
      if (do_entry) begin
        base_q <= base_q + GW'(pend_q);
        live_q <= live_q | need_m;
      end else if (do_ret) begin
        base_q <= ret_base;
        live_q <= (live_q & ~rel_m) | caller_m;
      end
    end
  end

  p_ovf_on_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> entry_i);

  p_unf_on_return_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> return_i && !entry_i);

  p_window_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q[base_q] && live_q[base_q + GW'(3)]);

  p_unwind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(do_entry) && do_ret |=> base_q == $past(base_q, 2));
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NREG = 64,
  parameter int DW   = 32,
  parameter int NRD  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [$clog2(NREG)-1:0] wr_addr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic [$clog2(NREG)-1:0] rd_addr_i [NRD],
  output logic [DW-1:0]           rd_data_o [NRD]
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = (wr_en_i && wr_addr_i == rd_addr_i[g]) ? wr_data_i
                                                                  : mem_q[rd_addr_i[g]];

    p_rd_after_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_en_i) && !wr_en_i && rd_addr_i[g] == $past(wr_addr_i)
      |-> rd_data_o[g] == $past(wr_data_i));
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int PHYS_REGS   = 64,
  parameter int DATA_W      = 32,
  parameter int STACK_DEPTH = 8,
  localparam int PW         = $clog2(PHYS_REGS),
  localparam int GW         = PW - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        rd_a_lreg_i,
  input  logic [3:0]        rd_b_lreg_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_lreg_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              call_req_i,
  input  logic [1:0]        call_inc_i,
  input  logic              entry_i,
  input  logic              return_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic [PW-1:0]     rd_a_paddr_o,
  output logic [PW-1:0]     rd_b_paddr_o,
  output logic [PW-1:0]     wr_paddr_o,
  output logic [GW-1:0]     win_base_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam int NGRP = PHYS_REGS / 4;

  logic [GW-1:0]     base;
  logic [PW-1:0]     rd_addr [2];
  logic [DATA_W-1:0] rd_data [2];

  rwin_window #(.NGRP(NGRP), .DEPTH(STACK_DEPTH)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_req_i  (call_req_i),
    .call_inc_i  (inc_t'(call_inc_i)),
    .entry_i     (entry_i),
    .return_i    (return_i),
    .base_o      (base),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  // modulo comes free from the power-of-two width
  assign rd_a_paddr_o = {base, 2'b00} + PW'(rd_a_lreg_i);
  assign rd_b_paddr_o = {base, 2'b00} + PW'(rd_b_lreg_i);
  assign wr_paddr_o   = {base, 2'b00} + PW'(wr_lreg_i);
  assign rd_addr[0]   = rd_a_paddr_o;
  assign rd_addr[1]   = rd_b_paddr_o;

  rwin_store #(.NREG(PHYS_REGS), .DW(DATA_W), .NRD(2)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_paddr_o),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign win_base_o  = base;

  p_base_moves_only_on_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_i && !return_i |=> $stable(win_base_o));
endmodule

// File: tb/sim_rwin_regfile.sv
module sim_rwin_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int PHYS = 32;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    rd_a_lreg = '0, rd_b_lreg = '0, wr_lreg = '0;
  logic          wr_en = 1'b0, call_req = 1'b0, entry = 1'b0, ret = 1'b0;
  logic [1:0]    call_inc = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic [4:0]    rd_a_paddr, rd_b_paddr, wr_paddr;
  logic [2:0]    win_base;
  logic          ovf, unf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwin_regfile #(.PHYS_REGS(PHYS), .DATA_W(DW), .STACK_DEPTH(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_lreg_i(rd_a_lreg), .rd_b_lreg_i(rd_b_lreg),
    .wr_en_i(wr_en), .wr_lreg_i(wr_lreg), .wr_data_i(wr_data),
    .call_req_i(call_req), .call_inc_i(call_inc),
    .entry_i(entry), .return_i(ret),
    .rd_a_data_o(rd_a_data), .rd_b_data_o(rd_b_data),
    .rd_a_paddr_o(rd_a_paddr), .rd_b_paddr_o(rd_b_paddr), .wr_paddr_o(wr_paddr),
    .win_base_o(win_base), .overflow_o(ovf), .underflow_o(unf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_inc(input logic [1:0] code);
    call_req = 1'b1; call_inc = code;
    step();
    call_req = 1'b0;
  endtask

  task automatic do_entry(input string req, input logic exp_ovf, input int exp_base);
    entry = 1'b1;
    #1 chk(req, "overflow", 32'(ovf), 32'(exp_ovf));
    step();
    entry = 1'b0;
    #1 chk(req, "base after entry", 32'(win_base), 32'(exp_base));
  endtask

  task automatic do_ret(input string req, input logic exp_unf, input int exp_base);
    ret = 1'b1;
    #1 chk(req, "underflow", 32'(unf), 32'(exp_unf));
    step();
    ret = 1'b0;
    #1 chk(req, "base after return", 32'(win_base), 32'(exp_base));
  endtask

  task automatic t_reset();
    rd_a_lreg = 4'd9; rd_b_lreg = 4'd15; wr_lreg = 4'd3;
    #1;
    chk("R1", "base", 32'(win_base), 0);
    chk("R1", "overflow", 32'(ovf), 0);
    chk("R1", "underflow", 32'(unf), 0);
    chk("R1", "rd_a paddr", 32'(rd_a_paddr), 9);
    chk("R1", "rd_b paddr", 32'(rd_b_paddr), 15);
    chk("R1", "wr paddr", 32'(wr_paddr), 3);
  endtask

  task automatic t_storage();
    wr_en = 1'b1; wr_lreg = 4'd7; wr_data = 32'h0000_0077;
    step();
    wr_lreg = 4'd5; wr_data = 32'h0000_0055; rd_a_lreg = 4'd5; rd_b_lreg = 4'd7;
    #1;
    chk("R10", "forwarded read", rd_a_data, 32'h55);
    chk("R11", "port b stored", rd_b_data, 32'h77);
    step();
    wr_en = 1'b0;
    #1;
    chk("R11", "port a stored", rd_a_data, 32'h55);
    chk("R11", "port b independent", rd_b_data, 32'h77);
  endtask

  task automatic t_overlap();
    wr_en = 1'b1; wr_lreg = 4'd6; wr_data = 32'h0000_00A6;
    step();
    wr_en = 1'b0;
    set_inc(2'd1);
    do_entry("R3", 1'b0, 1);
    rd_a_lreg = 4'd2; wr_lreg = 4'd10;
    #1;
    chk("R5", "callee r2 data", rd_a_data, 32'hA6);
    chk("R2", "callee r2 paddr", 32'(rd_a_paddr), 6);
    chk("R2", "callee wr paddr", 32'(wr_paddr), 14);
    do_ret("R4", 1'b0, 0);
  endtask

  task automatic t_code_zero();
    set_inc(2'd2);
    set_inc(2'd0);
    do_entry("R3", 1'b0, 2);
    do_ret("R4", 1'b0, 0);
  endtask

  task automatic t_mixed();
    set_inc(2'd2); do_entry("R3", 1'b0, 2);
    set_inc(2'd1); do_entry("R3", 1'b0, 3);
    set_inc(2'd3); do_entry("R7", 1'b1, 6);
    rd_a_lreg = 4'd15; rd_b_lreg = 4'd0;
    #1;
    chk("R6", "wrapped paddr", 32'(rd_a_paddr), 7);
    chk("R2", "base paddr", 32'(rd_b_paddr), 24);
    do_ret("R4", 1'b0, 3);
    do_ret("R4", 1'b0, 2);
    do_ret("R8", 1'b1, 0);
  endtask

  task automatic t_wrap();
    set_inc(2'd3);
    do_entry("R7", 1'b0, 3);
    do_entry("R7", 1'b1, 6);
    do_entry("R6", 1'b1, 1);
    do_ret("R8", 1'b0, 6);
    do_ret("R8", 1'b1, 3);
    do_ret("R8", 1'b1, 0);
  endtask

  task automatic t_edges();
    do_ret("R9", 1'b0, 0);
    entry = 1'b1; ret = 1'b1;
    #1 chk("R9", "no underflow on joint strobe", 32'(unf), 0);
    step();
    entry = 1'b0; ret = 1'b0;
    #1 chk("R9", "entry wins over return", 32'(win_base), 3);
    do_ret("R9", 1'b0, 0);
  endtask

  task automatic t_full();
    set_inc(2'd1);
    for (int i = 1; i <= 4; i++) do_entry("R9", 1'b0, i);
    do_entry("R9", 1'b0, 4);
    for (int i = 3; i >= 0; i--) do_ret("R9", 1'b0, i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_storage();
    t_overlap();
    t_code_zero();
    t_mixed();
    t_wrap();
    t_edges();
    t_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule